// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block places a small word-addressed register file in front of an 8-bit, full-duplex SPI shift engine. A host reaches it over a simple synchronous bus with a byte address, separate write and read strobes, write data, read data and a ready handshake. The decoded window covers 1 KiB. Two control words are fully writable. A status word reports the receive flag and the busy state. A single data register serves as both the transmit and the receive buffer. Five further registers exist only so that software written for the usual layout finds them at their expected offsets. They read back fixed values and discard writes.

The engine runs only when the enable bit and the master bit are both set in the first control word. In that state, any access to the data register launches an exchange on the SPI pins. A write transmits the written byte. A read transmits the byte already held. In both cases the bus is stalled with ready low until the last bit has been shifted, and the received byte then replaces the data register. The exchange uses mode 0: the clock idles low, MOSI is set up while the clock is low, and MISO is captured on each rising edge. The clock is the system clock divided by the even parameter `DIV`. Chip select is held low across all eight bits.

Top module: `spi_regmap_master`

## Requirements
- R1: After reset the words read as follows, where offset is the byte address: 0x00 = 0, 0x04 = 0, 0x08 = 0x0A, 0x0C = 0x0C, 0x10 = 0x07, 0x14 = 0, 0x18 = 0, 0x1C = 0, 0x20 = 0x02.
- R2: Address bits [9:2] select the word. Every offset inside the 1 KiB window that is not listed in R1 reads 0, and a write to such an offset changes no register.
- R3: Control word 0x00 and control word 0x04 store and return all 32 written bits.
- R4: Writes to 0x08, 0x10, 0x14, 0x18, 0x1C and 0x20 are discarded, and those words keep the values given in R1.
- R5: When bit 6 (enable) and bit 2 (master) of 0x00 are both set, a write to 0x0C sends write-data bits [7:0] MSB first. The access completes after the exchange. The data word then holds the received byte, zero-extended, and status bit 0 (receive flag) is 1.
- R6: When R5's enable condition holds, a read of 0x0C sends the low byte of the held data word MSB first and returns the received byte, zero-extended. After the access, status bit 0 is 0 and the data word holds the received byte.
- R7: When the enable condition does not hold, a write to 0x0C stores all 32 bits and a read of 0x0C returns the stored word. A read also clears status bit 0. In both cases chip select stays high and SCLK stays low.
- R8: Each exchange produces exactly 8 SCLK rising edges spaced `DIV` clocks apart, with chip select low throughout. MOSI changes only while SCLK is low. SCLK is low whenever chip select is high.
- R9: Status bits 1 and 3 always read 1. Status bit 7 (busy) is 1 only during an exchange, and ready is low throughout an exchange. An access to 0x0C that starts an exchange sees ready low on exactly 8*DIV+1 consecutive clock cycles.
- R10: Accesses to any register other than 0x0C, and to 0x0C while the enable condition is false, complete in the cycle they are presented, with ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | Byte address inside the window |
| bus_wr | input | 1 | Write strobe, held until ready |
| bus_rd | input | 1 | Read strobe, held until ready |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while ready is high |
| bus_ready | output | 1 | Access completes on a clock edge where ready is high |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
A wrong internal state shows up at the ports within one access. If the receive flag is corrupted, the next status read differs from 0x0A or 0x0B. If the data register is corrupted, the next enabled read shifts a wrong byte onto MOSI, which the slave model captures. If the shift state machine is corrupted, the number of stalled cycles, the count of SCLK rising edges or the spacing between those edges differs during the same exchange. A wrong decode shows up immediately as a nonzero word at an unlisted offset, or as a fixed register that takes a written value.

// File: rtl/spi_regmap_master.sv
module spi_regmap_master #(
  parameter int DIV    = 4,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int BITS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);

  localparam int HALF  = DIV / 2;
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BIT_W = $clog2(BITS);
  localparam int WA_W  = ADDR_W - 2;

  localparam logic [WA_W-1:0] W_CTL_A  = WA_W'(0);
  localparam logic [WA_W-1:0] W_CTL_B  = WA_W'(1);
  localparam logic [WA_W-1:0] W_STAT   = WA_W'(2);
  localparam logic [WA_W-1:0] W_DATA   = WA_W'(3);
  localparam logic [WA_W-1:0] W_POLY   = WA_W'(4);
  localparam logic [WA_W-1:0] W_RXSUM  = WA_W'(5);
  localparam logic [WA_W-1:0] W_TXSUM  = WA_W'(6);
  localparam logic [WA_W-1:0] W_AUDCFG = WA_W'(7);
  localparam logic [WA_W-1:0] W_AUDPRE = WA_W'(8);

  localparam logic [DATA_W-1:0] DATA_RST = DATA_W'(32'h0C);
  localparam logic [DATA_W-1:0] POLY_VAL = DATA_W'(32'h07);
  localparam logic [DATA_W-1:0] PRE_VAL  = DATA_W'(32'h02);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_DONE} state_t;

  state_t             st;
  logic [DATA_W-1:0]  ctl_a, ctl_b, data_q;
  logic               rx_full, op_wr;
  logic [BITS-1:0]    tx_sh, rx_sh;
  logic [CNT_W-1:0]   div_cnt;
  logic [BIT_W-1:0]   bit_idx;

  wire [WA_W-1:0] widx     = bus_addr[ADDR_W-1:2];
  wire            req      = bus_wr | bus_rd;
  wire            data_sel = (widx == W_DATA);
  wire            enabled  = ctl_a[6] & ctl_a[2];
  wire            launch   = (st == ST_IDLE) && req && data_sel && enabled;
  wire            busy     = (st == ST_SHIFT);
  wire            tick     = (div_cnt == CNT_W'(HALF - 1));
  wire            plain    = (st == ST_IDLE) && req && !launch;

  assign bus_ready = (st == ST_DONE) || plain;
  assign spi_mosi  = tx_sh[BITS-1];

  always_comb begin
    unique case (widx)
      W_CTL_A:  bus_rdata = ctl_a;
      W_CTL_B:  bus_rdata = ctl_b;
      W_STAT:   bus_rdata = DATA_W'({busy, 3'b000, 1'b1, 1'b0, 1'b1, rx_full});
      W_DATA:   bus_rdata = data_q;
      W_POLY:   bus_rdata = POLY_VAL;
      W_AUDPRE: bus_rdata = PRE_VAL;
      default:  bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_a <= '0;
      ctl_b <= '0;
    end else if (plain && bus_wr) begin
      if (widx == W_CTL_A) ctl_a <= bus_wdata;
      if (widx == W_CTL_B) ctl_b <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      data_q   <= DATA_RST;
      rx_full  <= 1'b0;
      op_wr    <= 1'b0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      div_cnt  <= '0;
      bit_idx  <= '0;
      spi_sclk <= 1'b0;
      spi_cs_n <= 1'b1;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (launch) begin
            st       <= ST_SHIFT;
            op_wr    <= bus_wr;
            tx_sh    <= bus_wr ? bus_wdata[BITS-1:0] : data_q[BITS-1:0];
            div_cnt  <= '0;
            bit_idx  <= '0;
            spi_cs_n <= 1'b0;
          end else if (plain && data_sel) begin
            if (bus_wr) data_q <= bus_wdata;
            else        rx_full <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            div_cnt  <= '0;
            spi_sclk <= ~spi_sclk;
            if (!spi_sclk) begin
              rx_sh <= {rx_sh[BITS-2:0], spi_miso};
            end else if (bit_idx == BIT_W'(BITS - 1)) begin
              st       <= ST_DONE;
              spi_cs_n <= 1'b1;
              data_q   <= DATA_W'(rx_sh);
              rx_full  <= op_wr;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              tx_sh   <= {tx_sh[BITS-2:0], 1'b0};
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R8
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> $stable(spi_mosi));

  // R9
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !bus_ready);

  // R9
  busy_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !spi_cs_n);

  // R4
  status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_ready && widx == W_STAT) |=> $stable(rx_full));

  // R7
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_IDLE) && req && data_sel && !enabled) |=> (spi_cs_n && !spi_sclk));

endmodule

// File: tb/spi_regmap_master_tb.sv
module spi_regmap_master_tb;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready, spi_sclk, spi_mosi, spi_cs_n;
  logic        spi_miso = 1'b0;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  spi_regmap_master #(.DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  // slave model and pin monitors
  logic [7:0] slave_byte = '0, slave_sh = '0, mosi_cap = '0;
  int rises = 0, cs_falls = 0, bad_period = 0, sclk_unselected = 0;
  int cyc = 0, last_rise = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (spi_cs_n && spi_sclk) sclk_unselected <= sclk_unselected + 1;
  end

  always @(negedge spi_cs_n) begin
    cs_falls = cs_falls + 1;
    slave_sh = slave_byte;
    spi_miso = slave_sh[7];
    rises = 0;
    mosi_cap = '0;
  end

  always @(posedge spi_sclk) begin
    mosi_cap = {mosi_cap[6:0], spi_mosi};
    if (rises > 0 && (cyc - last_rise) != DIV) bad_period = bad_period + 1;
    last_rise = cyc;
    rises = rises + 1;
  end

  always @(negedge spi_sclk) begin
    slave_sh = {slave_sh[6:0], 1'b0};
    spi_miso = slave_sh[7];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [9:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output int stalls);
    @(negedge clk);
    bus_addr = addr; bus_wdata = wd; bus_wr = wr; bus_rd = !wr;
    stalls = 0;
    #0;
    while (!bus_ready) begin
      stalls++;
      @(negedge clk);
    end
    rd = bus_rdata;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] reset_val(input logic [9:0] a);
    case (a)
      10'h008: return 32'h0A;
      10'h00C: return 32'h0C;
      10'h010: return 32'h07;
      10'h020: return 32'h02;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] status_exp(input logic rxf);
    return {28'h0, 4'b1010} | {31'h0, rxf};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd, model_dr, v;
    logic [7:0]  txb;
    int st;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    for (int i = 0; i < 9; i++) begin
      access(1'b0, 10'(i * 4), 32'h0, rd, st);
      check("R1", rd, reset_val(10'(i * 4)));
      check("R10", st, 0);
    end

    // R2 unlisted offsets read zero, write has no effect
    access(1'b0, 10'h024, 0, rd, st); check("R2", rd, 0);
    access(1'b0, 10'h3FC, 0, rd, st); check("R2", rd, 0);
    access(1'b1, 10'h200, 32'hFFFF_FFFF, rd, st);
    access(1'b0, 10'h200, 0, rd, st); check("R2", rd, 0);
    for (int i = 0; i < 9; i++) begin
      access(1'b0, 10'(i * 4), 32'h0, rd, st);
      check("R2", rd, reset_val(10'(i * 4)));
    end

    // R3 control words read/write
    for (int i = 0; i < 4; i++) begin
      v = $urandom();
      access(1'b1, 10'h004, v, rd, st);
      access(1'b0, 10'h004, 0, rd, st); check("R3", rd, v);
      v = $urandom() & ~32'h44;
      access(1'b1, 10'h000, v, rd, st);
      access(1'b0, 10'h000, 0, rd, st); check("R3", rd, v);
    end

    // R4 fixed registers ignore writes
    for (int i = 2; i < 9; i++) begin
      if (i == 3) continue;
      access(1'b1, 10'(i * 4), $urandom(), rd, st);
      access(1'b0, 10'(i * 4), 0, rd, st);
      check("R4", rd, reset_val(10'(i * 4)));
    end

    // R7 disabled data access: no bus activity
    access(1'b1, 10'h000, 32'h0000_0040, rd, st);
    model_dr = $urandom();
    access(1'b1, 10'h00C, model_dr, rd, st); check("R10", st, 0);
    access(1'b0, 10'h00C, 0, rd, st); check("R7", rd, model_dr);
    check("R7", cs_falls, 0);
    access(1'b1, 10'h000, 32'h0000_0004, rd, st);
    access(1'b0, 10'h00C, 0, rd, st); check("R7", rd, model_dr);
    check("R7", cs_falls, 0);

    // enable master
    access(1'b1, 10'h000, 32'h0000_0044, rd, st);

    // directed corner bytes then random mix
    for (int n = 0; n < 24; n++) begin
      logic do_wr;
      do_wr = (n < 4) ? n[0] : 1'($urandom());
      slave_byte = (n == 0) ? 8'h00 : (n == 1) ? 8'hFF : 8'($urandom());
      txb = (n == 2) ? 8'h80 : (n == 3) ? 8'h01 : 8'($urandom());
      if (do_wr) begin
        access(1'b1, 10'h00C, {24'($urandom()), txb}, rd, st);
        check("R5", mosi_cap, txb);
        model_dr = {24'h0, slave_byte};
        access(1'b0, 10'h008, 0, rd, st); check("R5", rd, status_exp(1'b1));
      end else begin
        access(1'b0, 10'h00C, 0, rd, st);
        check("R6", mosi_cap, model_dr[7:0]);
        check("R6", rd, {24'h0, slave_byte});
        model_dr = {24'h0, slave_byte};
        access(1'b0, 10'h008, 0, rd, st); check("R6", rd, status_exp(1'b0));
      end
      check("R9", st, 0);
      check("R8", rises, 8);
    end
    check("R8", bad_period, 0);
    check("R8", sclk_unselected, 0);

    // R9 stall length on one enabled access
    slave_byte = 8'hA5;
    access(1'b1, 10'h00C, 32'h3C, rd, st);
    check("R9", st, 8 * DIV + 1);
    access(1'b0, 10'h008, 0, rd, st); check("R9", rd, 32'h0B);

    // R7 disabled read clears flag and returns held word
    access(1'b1, 10'h000, 32'h0, rd, st);
    v = cs_falls;
    access(1'b0, 10'h00C, 0, rd, st); check("R7", rd, 32'hA5);
    access(1'b0, 10'h008, 0, rd, st); check("R7", rd, 32'h0A);
    check("R7", cs_falls, v);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule